// File: doc/BRIEF.md
# Pin-strobed configuration register port

This block receives configuration writes from a host that drives a few general-purpose pins. The host sets a 3-bit address and a 3-bit value. It then pulls an enable line low and raises it again. When the block sees the enable line go from low to high, it stores the value in the register that the address selects. There are eight 3-bit registers, and all of them are presented at once to the LED logic downstream.

The pins are asynchronous to the system clock. Every pin therefore passes through a two-flop synchroniser. The edge detector looks at the synchronised enable line. In the cycle where it finds a rising edge, it samples the synchronised address and data together. The block also drives a one-cycle write pulse and the index that was written, so that downstream pattern generators can restart.

Top module: `strobe_cfg_port`

## Requirements
- R1: After reset, all eight registers read zero, the write pulse is low and the write index is zero.
- R2: A low-to-high transition of `pin_strobe` stores `pin_data` into register `pin_addr`. Register i appears on `cfg_flat[3*i+2:3*i]`.
- R2 (register usage): index 0 holds the front LED mode and index 1 the front LED brightness. Index 2 holds the brightness shared by the disk LEDs. Indices 3 to 7 hold the modes of disk LEDs 0 to 4.
- R3: A write leaves every register other than the addressed one unchanged.
- R4: Holding `pin_strobe` high or holding it low for any number of cycles causes no further write and no further pulse.
- R5: Each write produces exactly one cycle of `wr_pulse`. In that same cycle, `wr_index` equals the written address and the new register value is visible on `cfg_flat`.
- R6: When the strobe rises just after a clock edge and the pins are stable, the new value and `wr_pulse` appear after the third following rising clock edge. They are not visible after the second.
- R7: Address and data are sampled from their synchronised copies. Pin changes made two clock cycles after the strobe rises do not alter the write in progress.
- R8: A strobe that is already high when reset is released does not cause a write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pin_addr | input | 3 | Asynchronous register address from the host |
| pin_data | input | 3 | Asynchronous write value from the host |
| pin_strobe | input | 1 | Asynchronous write enable; a rising edge commits the write |
| cfg_flat | output | 24 | All eight registers; register i at bits 3i+2:3i |
| wr_pulse | output | 1 | One-cycle pulse when a register is updated |
| wr_index | output | 3 | Index of the register written at the last pulse |

## Verification
A wrong synchroniser depth shows up as the new value and the pulse arriving one edge too early or too late. The bench checks this to the exact cycle. A broken edge detector shows as extra pulses while the strobe is held, or as a missing write. Either one shifts the running pulse count, and the full register image is compared after every write. A wrong address decode or sampling skew puts the value in the wrong field of `cfg_flat`. This is caught within the check that follows that write.

// File: rtl/strobe_cfg_port.sv
module strobe_cfg_port #(
  parameter int AW          = 3,
  parameter int DW          = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [AW-1:0]            pin_addr,
  input  logic [DW-1:0]            pin_data,
  input  logic                     pin_strobe,
  output logic [(1<<AW)*DW-1:0]    cfg_flat,
  output logic                     wr_pulse,
  output logic [AW-1:0]            wr_index
);
  localparam int NREG = 1 << AW;
  localparam int LAST = SYNC_STAGES - 1;

  logic [SYNC_STAGES-1:0][AW-1:0] a_sync;
  logic [SYNC_STAGES-1:0][DW-1:0] d_sync;
  logic [SYNC_STAGES:0]           s_sync;
  logic [NREG-1:0][DW-1:0]        regs_q;
  logic                           rise;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_sync <= '0;
      d_sync <= '0;
      s_sync <= '1;
    end else begin
      a_sync <= {a_sync[SYNC_STAGES-2:0], pin_addr};
      d_sync <= {d_sync[SYNC_STAGES-2:0], pin_data};
      s_sync <= {s_sync[SYNC_STAGES-1:0], pin_strobe};
    end
  end

  assign rise = s_sync[LAST] & ~s_sync[SYNC_STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      regs_q   <= '0;
      wr_pulse <= 1'b0;
      wr_index <= '0;
    end else begin
      wr_pulse <= rise;
      if (rise) begin
        regs_q[a_sync[LAST]] <= d_sync[LAST];
        wr_index             <= a_sync[LAST];
      end
    end
  end

  assign cfg_flat = regs_q;

  AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_pulse |=> !wr_pulse); // R5
  AST_EDGE_FROM_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    wr_pulse |-> !$past(s_sync[LAST], 2)); // R4
  AST_WRITE_VALUE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_pulse |-> regs_q[wr_index] == $past(d_sync[LAST])); // R2
  AST_WRITE_INDEX: assert property (@(posedge clk) disable iff (!rst_n)
    wr_pulse |-> wr_index == $past(a_sync[LAST])); // R5

  for (genvar i = 0; i < NREG; i++) begin : g_keep
    AST_OTHERS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!wr_pulse || wr_index != AW'(i)) |-> $stable(regs_q[i])); // R3
  end
endmodule

// File: tb/strobe_cfg_port_tb.sv
`timescale 1ns/1ps
module strobe_cfg_port_tb;
  logic clk = 0, rst_n = 0;
  logic [2:0] pin_addr = 0, pin_data = 0;
  logic pin_strobe = 0;
  logic [23:0] cfg_flat;
  logic wr_pulse;
  logic [2:0] wr_index;

  int vectors = 0, miscompares = 0, pulses = 0, exp_pulses = 0;
  logic [2:0] model [8];
  bit done = 0;

  always #2 clk = ~clk;

  strobe_cfg_port u_dut (.clk, .rst_n, .pin_addr, .pin_data, .pin_strobe,
                         .cfg_flat, .wr_pulse, .wr_index);

  always @(posedge clk) #1 if (rst_n && wr_pulse) pulses++;

  function automatic logic [23:0] packed_model();
    logic [23:0] v;
    for (int i = 0; i < 8; i++) v[3*i +: 3] = model[i];
    return v;
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic edges(int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic host_write(logic [2:0] a, logic [2:0] d, int lo, int hi);
    pin_addr = a; pin_data = d;
    edges(1);
    pin_strobe = 0;
    edges(lo);
    pin_strobe = 1;
    model[a] = d; exp_pulses++;
    edges(2);
    pin_addr = $urandom; pin_data = $urandom;
    edges(hi);
  endtask

  initial begin
    void'($urandom(32'h5eed));
    for (int i = 0; i < 8; i++) model[i] = 0;
    pin_strobe = 1;
    edges(3);
    chk("R1 regs", cfg_flat, 0);
    chk("R1 pulse", wr_pulse, 0);
    chk("R1 index", wr_index, 0);
    rst_n = 1;
    edges(8);
    chk("R8 regs", cfg_flat, 0);
    chk("R8 pulses", pulses, 0);

    // R6 exact latency, R5 pulse and index
    pin_addr = 3'd5; pin_data = 3'd6; pin_strobe = 0;
    edges(4);
    pin_strobe = 1;
    edges(2);
    chk("R6 not yet", cfg_flat[17:15], 0);
    chk("R6 no pulse yet", wr_pulse, 0);
    edges(1);
    model[5] = 6; exp_pulses++;
    chk("R6 value", cfg_flat, packed_model());
    chk("R5 pulse", wr_pulse, 1);
    chk("R5 index", wr_index, 5);
    edges(1);
    chk("R5 pulse ends", wr_pulse, 0);

    // R2 register map: front mode blue, brightness, disk brightness, disk modes
    host_write(3'd0, 3'd1, 3, 3);
    host_write(3'd1, 3'd3, 3, 3);
    host_write(3'd2, 3'd3, 3, 3);
    host_write(3'd3, 3'd1, 3, 3);
    host_write(3'd7, 3'd7, 3, 3);
    chk("R2 map", cfg_flat, packed_model());

    // R4 hold high then hold low
    edges(20);
    pin_strobe = 0;
    edges(20);
    chk("R4 held", pulses, exp_pulses);
    chk("R4 regs", cfg_flat, packed_model());

    // R7 pins changed after rise (inside host_write), R3 random
    for (int k = 0; k < 60; k++) begin
      host_write($urandom, $urandom, 1 + $urandom % 4, 1 + $urandom % 5);
      chk("R3 R7 image", cfg_flat, packed_model());
    end
    chk("R5 pulse count", pulses, exp_pulses);
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin #800000; miscompares++; vectors++; $display("FAIL watchdog expired"); end
    join_any
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule